// File: doc/BRIEF.md
# Strobe-Multiplexed DRAM Access Controller

This block sits between a simple single-word request port and a dynamic memory device whose address pins are shared between the row half and the column half of the address. An accepted request starts an access cycle. The controller puts the row half on the shared pins and pulls the active-low row strobe low. After a set number of clocks it switches the pins to the column half and pulls the active-low column strobe low. For a read, it captures the device's data once the row-access time has run out. It then releases both strobes and stays busy until the full cycle time has passed, so that the device can finish writing the row back.

A free-running refresh timer divides the refresh period by the number of rows. Each time that interval expires it raises a refresh request. At the next idle point the controller serves it ahead of any user request. A refresh is a row-only cycle: the row strobe drops, the column strobe stays high, and the row number comes from a wrapping counter. Because touching a row restores every cell in it, one refresh per row per period keeps the whole array alive.

All timings are parameters counted in clocks. The requester sees a single `busy` flag. A request is taken on a clock edge only when `busy` is low.

Top module: `dram_strobe_ctrl`

## Requirements
- R1: After reset, both strobes are high, write enable is high, the data driver is off, `busy` is low and `rd_valid` is low.
- R2: A request seen with `req_valid` high and `busy` low at a clock edge makes the row strobe go low in the next cycle. From that cycle on, `dram_addr` carries the row half, which is `req_addr[ADDR_W-1:COL_W]`, until the column strobe falls.
- R3: The column strobe falls exactly T_RCD cycles after the row strobe falls, with the column half `req_addr[COL_W-1:0]` on `dram_addr`. It is never low while the row strobe is high.
- R4: For a read, `rd_valid` is a one-cycle pulse exactly T_RAC cycles after the row strobe falls. `rd_data` holds the value `dram_dq_in` had in the cycle before.
- R5: For a write, `dram_we_n` is low and `dram_dq_oe` is high with the request data on `dram_dq_out` while the column strobe is low. For a read, `dram_we_n` stays high. Both strobes rise exactly T_RAC cycles after the row strobe falls.
- R6: `busy` is high whenever a strobe is low. After a cycle it goes low exactly T_RC cycles after the row strobe fell, unless a refresh is pending. Two row-strobe falls are always at least T_RC+1 cycles apart.
- R7: A request presented while `busy` is high is ignored. It starts no cycle and writes nothing.
- R8: With no user traffic, refresh cycles start exactly REF_PERIOD_CLKS/2^ROW_W clocks apart. In a refresh cycle the column strobe stays high and no read data is returned.
- R9: Refresh rows go 0, 1, ..., 2^ROW_W-1 in order and then wrap to 0.
- R10: A pending refresh holds `busy` high and is served at the next idle point before any user request. Under back-to-back requests, refresh intervals never grow beyond the nominal interval plus T_RC+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | Full word address, row half on top |
| req_wdata | input | DATA_W | Write data |
| busy | output | 1 | Access or refresh in progress or pending |
| rd_valid | output | 1 | One-cycle read data pulse |
| rd_data | output | DATA_W | Captured read data |
| dram_addr | output | max(ROW_W,COL_W) | Shared row/column address pins |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_dq_out | output | DATA_W | Data driven to device |
| dram_dq_oe | output | 1 | Data driver enable |
| dram_dq_in | input | DATA_W | Data returned by device |

## Verification
Every result is timed from the cycle in which the row strobe falls, one cycle after the accepting edge. The column strobe is due T_RCD cycles later, read data and strobe release T_RAC cycles later, and the drop of `busy` T_RC cycles later. A monitor samples on the falling clock edge and keeps its own cycle count from each row-strobe fall. Each event is compared against that count and popped in order from a scoreboard queue that the driver filled at acceptance. Refresh spacing is measured between successive row-only cycles. The exact interval is checked only when no user access fell inside the last two windows, and a bounded delay is checked otherwise.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ROW  = 2'd1,
    PH_COL  = 2'd2,
    PH_TAIL = 2'd3
  } phase_t;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dsc_refresh_sched.sv
module dsc_refresh_sched #(
  parameter int ROW_W   = 4,
  parameter int REF_INT = 125
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ack,
  output logic             pending,
  output logic [ROW_W-1:0] row
);

  localparam int TW = $clog2(REF_INT + 1);

  logic [TW-1:0] tmr;
  logic          tick;

  assign tick = (tmr == TW'(REF_INT - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      tmr     <= '0;
      pending <= 1'b0;
      row     <= '0;
    end else begin
      tmr     <= tick ? '0 : tmr + 1'b1;
      pending <= (pending & ~ack) | tick;
      if (ack) row <= row + 1'b1;
    end
  end

endmodule

// File: rtl/dsc_sequencer.sv
module dsc_sequencer
  import dsc_pkg::*;
#(
  parameter int T_RCD = 2,
  parameter int T_RAC = 5,
  parameter int T_RC  = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic req_valid,
  input  logic ref_pending,
  output logic busy,
  output logic start_acc,
  output logic start_ref,
  output logic col_load,
  output logic capture,
  output logic strobe_off,
  output logic ras_n,
  output logic cas_n
);

  localparam int CNT_W = $clog2(T_RC + 1);

  phase_t           st;
  logic [CNT_W-1:0] cnt;
  logic             ref_cyc;
  logic             col_hit;
  logic             rel_hit;
  logic             end_hit;

  assign start_ref  = (st == PH_IDLE) && ref_pending;
  assign start_acc  = (st == PH_IDLE) && !ref_pending && req_valid;
  assign col_hit    = (st == PH_ROW)  && (cnt == CNT_W'(T_RCD - 1));
  assign rel_hit    = (st == PH_COL)  && (cnt == CNT_W'(T_RAC - 1));
  assign end_hit    = (st == PH_TAIL) && (cnt == CNT_W'(T_RC - 1));
  assign col_load   = col_hit && !ref_cyc;
  assign capture    = rel_hit && !ref_cyc;
  assign strobe_off = rel_hit;
  assign busy       = (st != PH_IDLE) || ref_pending;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= PH_IDLE;
      cnt     <= '0;
      ref_cyc <= 1'b0;
      ras_n   <= 1'b1;
      cas_n   <= 1'b1;
    end else begin
      unique case (st)
        PH_IDLE: begin
          if (start_ref || start_acc) begin
            st      <= PH_ROW;
            cnt     <= '0;
            ref_cyc <= start_ref;
            ras_n   <= 1'b0;
          end
        end
        PH_ROW: begin
          cnt <= cnt + 1'b1;
          if (col_hit) begin
            st <= PH_COL;
            if (!ref_cyc) cas_n <= 1'b0;
          end
        end
        PH_COL: begin
          cnt <= cnt + 1'b1;
          if (rel_hit) begin
            st    <= PH_TAIL;
            ras_n <= 1'b1;
            cas_n <= 1'b1;
          end
        end
        PH_TAIL: begin
          cnt <= cnt + 1'b1;
          if (end_hit) st <= PH_IDLE;
        end
        default: st <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dsc_datapath.sv
module dsc_datapath #(
  parameter int ROW_W  = 4,
  parameter int COL_W  = 4,
  parameter int DATA_W = 8,
  parameter int MUX_W  = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start_acc,
  input  logic                   start_ref,
  input  logic                   col_load,
  input  logic                   capture,
  input  logic                   strobe_off,
  input  logic                   req_write,
  input  logic [ROW_W+COL_W-1:0] req_addr,
  input  logic [DATA_W-1:0]      req_wdata,
  input  logic [ROW_W-1:0]       ref_row,
  input  logic [DATA_W-1:0]      dq_in,
  output logic [MUX_W-1:0]       mux_addr,
  output logic                   we_n,
  output logic                   dq_oe,
  output logic [DATA_W-1:0]      dq_out,
  output logic                   rd_valid,
  output logic [DATA_W-1:0]      rd_data
);

  localparam int ADDR_W = ROW_W + COL_W;

  logic [COL_W-1:0]  lat_col;
  logic              lat_we;
  logic [DATA_W-1:0] lat_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      mux_addr <= '0;
      we_n     <= 1'b1;
      dq_oe    <= 1'b0;
      dq_out   <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
      lat_col  <= '0;
      lat_we   <= 1'b0;
      lat_data <= '0;
    end else begin
      rd_valid <= 1'b0;
      if (start_acc) begin
        mux_addr <= MUX_W'(req_addr[ADDR_W-1:COL_W]);
        lat_col  <= req_addr[COL_W-1:0];
        lat_we   <= req_write;
        lat_data <= req_wdata;
      end else if (start_ref) begin
        mux_addr <= MUX_W'(ref_row);
      end
      if (col_load) begin
        mux_addr <= MUX_W'(lat_col);
        we_n     <= !lat_we;
        dq_oe    <= lat_we;
        dq_out   <= lat_data;
      end
      if (strobe_off) begin
        we_n  <= 1'b1;
        dq_oe <= 1'b0;
      end
      if (capture && !lat_we) begin
        rd_valid <= 1'b1;
        rd_data  <= dq_in;
      end
    end
  end

endmodule

// File: rtl/dram_strobe_ctrl.sv
module dram_strobe_ctrl #(
  parameter int ROW_W           = 4,
  parameter int COL_W           = 4,
  parameter int DATA_W          = 8,
  parameter int T_RCD           = 2,
  parameter int T_RAC           = 5,
  parameter int T_RC            = 8,
  parameter int REF_PERIOD_CLKS = 2000
) (
  input  logic                                     clk,
  input  logic                                     rst,
  input  logic                                     req_valid,
  input  logic                                     req_write,
  input  logic [ROW_W+COL_W-1:0]                   req_addr,
  input  logic [DATA_W-1:0]                        req_wdata,
  output logic                                     busy,
  output logic                                     rd_valid,
  output logic [DATA_W-1:0]                        rd_data,
  output logic [dsc_pkg::max_of(ROW_W,COL_W)-1:0]  dram_addr,
  output logic                                     dram_ras_n,
  output logic                                     dram_cas_n,
  output logic                                     dram_we_n,
  output logic [DATA_W-1:0]                        dram_dq_out,
  output logic                                     dram_dq_oe,
  input  logic [DATA_W-1:0]                        dram_dq_in
);

  localparam int MUX_W   = dsc_pkg::max_of(ROW_W, COL_W);
  localparam int ROWS    = 1 << ROW_W;
  localparam int REF_INT = REF_PERIOD_CLKS / ROWS;

  logic             ref_pending;
  logic [ROW_W-1:0] ref_row;
  logic             start_acc;
  logic             start_ref;
  logic             col_load;
  logic             capture;
  logic             strobe_off;

  dsc_refresh_sched #(
    .ROW_W   (ROW_W),
    .REF_INT (REF_INT)
  ) ref_i (
    .clk     (clk),
    .rst     (rst),
    .ack     (start_ref),
    .pending (ref_pending),
    .row     (ref_row)
  );

  dsc_sequencer #(
    .T_RCD (T_RCD),
    .T_RAC (T_RAC),
    .T_RC  (T_RC)
  ) seq_i (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .ref_pending (ref_pending),
    .busy        (busy),
    .start_acc   (start_acc),
    .start_ref   (start_ref),
    .col_load    (col_load),
    .capture     (capture),
    .strobe_off  (strobe_off),
    .ras_n       (dram_ras_n),
    .cas_n       (dram_cas_n)
  );

  dsc_datapath #(
    .ROW_W  (ROW_W),
    .COL_W  (COL_W),
    .DATA_W (DATA_W),
    .MUX_W  (MUX_W)
  ) dp_i (
    .clk        (clk),
    .rst        (rst),
    .start_acc  (start_acc),
    .start_ref  (start_ref),
    .col_load   (col_load),
    .capture    (capture),
    .strobe_off (strobe_off),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .ref_row    (ref_row),
    .dq_in      (dram_dq_in),
    .mux_addr   (dram_addr),
    .we_n       (dram_we_n),
    .dq_oe      (dram_dq_oe),
    .dq_out     (dram_dq_out),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data)
  );

endmodule

// File: rtl/dsc_checker.sv
module dsc_checker #(
  parameter int MUX_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             busy,
  input logic             rd_valid,
  input logic [MUX_W-1:0] dram_addr,
  input logic             dram_ras_n,
  input logic             dram_cas_n,
  input logic             dram_we_n,
  input logic             dram_dq_oe
);

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (dram_ras_n && dram_cas_n && dram_we_n && !dram_dq_oe && !rd_valid));

  // R2
  row_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!dram_ras_n && dram_cas_n && $past(!dram_ras_n && dram_cas_n)) |-> $stable(dram_addr));

  // R3
  cas_inside_ras_chk: assert property (@(posedge clk) disable iff (rst)
    !dram_cas_n |-> !dram_ras_n);

  // R4
  rd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);

  // R4
  rd_in_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> busy);

  // R5
  dq_drive_chk: assert property (@(posedge clk) disable iff (rst)
    dram_dq_oe |-> (!dram_cas_n && !dram_we_n));

  // R6
  strobe_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (!dram_ras_n || !dram_cas_n) |-> busy);

endmodule

bind dram_strobe_ctrl dsc_checker #(
  .MUX_W (dsc_pkg::max_of(ROW_W, COL_W))
) chk_i (
  .clk        (clk),
  .rst        (rst),
  .busy       (busy),
  .rd_valid   (rd_valid),
  .dram_addr  (dram_addr),
  .dram_ras_n (dram_ras_n),
  .dram_cas_n (dram_cas_n),
  .dram_we_n  (dram_we_n),
  .dram_dq_oe (dram_dq_oe)
);

// File: tb/dram_strobe_ctrl_tb_top.sv
module dram_strobe_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int ROW_W  = 4;
  localparam int COL_W  = 4;
  localparam int DATA_W = 8;
  localparam int T_RCD  = 2;
  localparam int T_RAC  = 5;
  localparam int T_RC   = 8;
  localparam int REF_P  = 2000;
  localparam int ROWS   = 16;
  localparam int NW     = 256;
  localparam int REF_INT = 125;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_write = 1'b0;
  logic [ROW_W+COL_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic busy, rd_valid, dram_ras_n, dram_cas_n, dram_we_n, dram_dq_oe;
  logic [DATA_W-1:0] rd_data, dram_dq_out, dram_dq_in;
  logic [3:0] dram_addr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_strobe_ctrl #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W),
    .T_RCD(T_RCD), .T_RAC(T_RAC), .T_RC(T_RC), .REF_PERIOD_CLKS(REF_P)
  ) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy),
    .rd_valid(rd_valid), .rd_data(rd_data), .dram_addr(dram_addr),
    .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
    .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
  );

  function automatic logic [DATA_W-1:0] seed(input int i);
    return DATA_W'(i * 7 + 3);
  endfunction

  // device model
  logic [DATA_W-1:0] mem [NW];
  logic m_ras_q, m_cas_q;
  logic [ROW_W-1:0] m_row;
  logic [COL_W-1:0] m_col;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NW; i++) mem[i] <= seed(i);
      m_ras_q <= 1'b1;
      m_cas_q <= 1'b1;
      m_row   <= '0;
      m_col   <= '0;
    end else begin
      m_ras_q <= dram_ras_n;
      m_cas_q <= dram_cas_n;
      if (!dram_ras_n && m_ras_q) m_row <= dram_addr[ROW_W-1:0];
      if (!dram_cas_n && m_cas_q) begin
        m_col <= dram_addr[COL_W-1:0];
        if (!dram_we_n) mem[{m_row, dram_addr[COL_W-1:0]}] <= dram_dq_out;
      end
    end
  end

  assign dram_dq_in = !dram_cas_n ? mem[{m_row, m_col}] : '0;

  // scoreboard
  typedef struct packed {
    logic [ROW_W-1:0]  row;
    logic [COL_W-1:0]  col;
    logic              we;
    logic [DATA_W-1:0] data;
  } acc_t;

  acc_t acc_q[$];
  logic [DATA_W-1:0] rd_q[$];
  logic [DATA_W-1:0] shadow [NW];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_req(input bit we, input int addr, input int data);
    acc_t e;
    @(negedge clk);
    while (busy) @(negedge clk);
    req_valid = 1'b1;
    req_write = we;
    req_addr  = 8'(addr);
    req_wdata = 8'(data);
    e.row  = 4'(addr >> COL_W);
    e.col  = 4'(addr);
    e.we   = we;
    e.data = 8'(data);
    acc_q.push_back(e);
    if (we) shadow[addr] = 8'(data);
    else rd_q.push_back(shadow[addr]);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // monitor
  int cyc = 0;
  int c = 1000;
  int last_ras = -1;
  int last_ref = -1;
  int refs = 0;
  int ref_row_exp = 0;
  bit acc_now = 0, acc_prev = 0, saw_cas = 0;
  logic p_ras = 1'b1, p_cas = 1'b1, p_busy = 1'b0;
  logic [ROW_W-1:0] row_at_ras = '0;

  always @(negedge clk) begin
    if (!rst) begin
      cyc++;
      if (p_ras && !dram_ras_n) begin
        if (last_ras >= 0)
          chk(cyc - last_ras >= T_RC + 1, "R6", "row strobe spacing", cyc - last_ras, T_RC + 1);
        last_ras = cyc;
        c = 0;
        saw_cas = 0;
        row_at_ras = dram_addr[ROW_W-1:0];
      end else begin
        c++;
      end
      if (p_cas && !dram_cas_n) begin
        saw_cas = 1;
        acc_now = 1;
        chk(c == T_RCD, "R3", "column strobe delay", c, T_RCD);
        if (acc_q.size() == 0) begin
          chk(0, "R7", "unexpected access started", 1, 0);
        end else begin
          acc_t e;
          e = acc_q.pop_front();
          chk(row_at_ras == e.row, "R2", "row half", row_at_ras, e.row);
          chk(dram_addr == e.col, "R3", "column half", dram_addr, e.col);
          chk(dram_we_n == !e.we, "R5", "write enable", dram_we_n, !e.we);
          if (e.we)
            chk(dram_dq_oe && dram_dq_out == e.data, "R5", "write data", dram_dq_out, e.data);
        end
      end
      if (rd_valid) begin
        chk(c == T_RAC, "R4", "read data timing", c, T_RAC);
        if (rd_q.size() == 0) chk(0, "R8", "read data without read", rd_data, 0);
        else begin
          logic [DATA_W-1:0] x;
          x = rd_q.pop_front();
          chk(rd_data == x, "R4", "read data", rd_data, x);
        end
      end
      if (!p_ras && dram_ras_n) begin
        chk(c == T_RAC, "R5", "strobe release", c, T_RAC);
        chk(dram_cas_n == 1'b1, "R5", "column strobe released", dram_cas_n, 1);
        if (!saw_cas) begin
          chk(row_at_ras == ROW_W'(ref_row_exp), "R9", "refresh row", row_at_ras, ref_row_exp);
          ref_row_exp = (ref_row_exp + 1) % ROWS;
          refs++;
          if (last_ref >= 0) begin
            if (!acc_now && !acc_prev)
              chk(cyc - last_ref == REF_INT, "R8", "refresh interval", cyc - last_ref, REF_INT);
            else
              chk(cyc - last_ref <= REF_INT + T_RC + 1, "R10", "refresh delay", cyc - last_ref, REF_INT + T_RC + 1);
          end
          last_ref = cyc;
          acc_prev = acc_now;
          acc_now = 0;
        end
      end
      if (p_busy && !busy)
        chk(c == T_RC, "R6", "busy release", c, T_RC);
      p_ras = dram_ras_n;
      p_cas = dram_cas_n;
      p_busy = busy;
    end
  end

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    int r0;
    for (int i = 0; i < NW; i++) shadow[i] = seed(i);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk(dram_ras_n && dram_cas_n && dram_we_n, "R1", "strobes idle", {dram_ras_n, dram_cas_n, dram_we_n}, 7);
    chk(!busy && !rd_valid && !dram_dq_oe, "R1", "flags idle", {busy, rd_valid, dram_dq_oe}, 0);

    // R4: reads of untouched words, R5: writes at both ends
    do_req(0, 8'h00, 0);
    do_req(0, 8'hFF, 0);
    do_req(1, 8'h00, 8'hA5);
    do_req(1, 8'hFF, 8'h5A);
    do_req(1, 8'h3C, 8'h81);
    do_req(0, 8'h00, 0);
    do_req(0, 8'hFF, 0);
    do_req(0, 8'h3C, 0);

    // R7: request during a busy cycle is dropped
    do_req(1, 8'h42, 8'h11);
    @(negedge clk);
    while (dram_ras_n) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h42; req_wdata = 8'hEE;
    @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    do_req(0, 8'h42, 0);

    // R10: back-to-back stream spanning several refresh intervals
    r0 = refs;
    for (int i = 0; i < 45; i++) begin
      do_req(i % 2, (i * 37) % NW, i * 5 + 1);
    end
    chk(refs - r0 >= 2, "R10", "refreshes during stream", refs - r0, 2);

    // R8, R9: idle refreshes through a full wrap
    r0 = refs;
    while (refs - r0 < ROWS + 3) @(negedge clk);
    repeat (T_RC + 2) @(negedge clk);
    chk(acc_q.size() == 0 && rd_q.size() == 0, "R7", "scoreboard drained", acc_q.size() + rd_q.size(), 0);
    finish_run();
  end

endmodule